// File: doc/BRIEF.md
# Paged Load/Store Sequencer

This block runs the seven data-movement instructions of a 16-bit word-addressed machine, one instruction at a time: three loads, three stores, and an effective-address computation. A single-cycle `start` pulse hands it the instruction word, the program counter and the values of the two registers the instruction names. The block then issues one or two memory requests, each held until the memory answers with `mem_rdy`. It ends with a one-cycle `done` pulse. On that cycle a load or address computation also writes the register file and the condition codes.

A page-relative address takes its upper seven bits from the program counter and its lower nine bits from the instruction, so memory is seen as 512-word pages. A based address adds an unsigned 6-bit field to a register. The indirect forms first read a pointer word at the page-relative address and then use that word as the real address.

The controller has four states. `S_IDLE` waits for `start`. `S_PTR` holds the pointer read of an indirect instruction. `S_ACC` holds the data read or write. `S_DONE` is the completion cycle. The transitions are as follows:
- `S_IDLE` goes to `S_ACC` on a direct or based load or store.
- `S_IDLE` goes to `S_PTR` on an indirect instruction.
- `S_IDLE` goes to `S_DONE` on an address computation.
- `S_IDLE` stays put on an unknown opcode.
- `S_PTR` goes to `S_ACC` on ready.
- `S_ACC` goes to `S_DONE` on ready.
- `S_DONE` goes back to `S_IDLE` unconditionally.

Top module: `pgls_seq`

## Requirements
- R1: Page-relative instructions (direct load 4'b0010, direct store 4'b0011, and the pointer read of both indirect forms) use address {pc[15:9], ir[8:0]}.
- R2: Based instructions (load 4'b0110, store 4'b0111) use address base + zero-extended ir[5:0]. The base register is selected by ir[8:6].
- R3: Indirect instructions (load 4'b1010, store 4'b1011) first read the pointer at the R1 address without writing memory, then access the address held in that pointer.
- R4: Address computation (4'b1110) writes {pc[15:9], ir[8:0]} to register ir[11:9] and raises no memory request.
- R5: Loads and address computation pulse cc_we with cc_nzp one-hot ({N,Z,P}: bit 2 negative, bit 1 zero, bit 0 positive) from the written value. Stores never pulse cc_we.
- R6: Stores write the value of register ir[11:9] to memory and never pulse rf_we.
- R7: mem_req stays high until mem_rdy is seen. mem_addr, mem_we and mem_wdata hold steady while waiting.
- R8: A start with any other opcode is ignored: no request, no busy, no done.
- R9: done is a one-cycle pulse. With L wait cycles per access, done is seen 1 cycle after start for address computation, L+2 for direct or based accesses, and 2L+3 for indirect ones. A start while busy is ignored.
- R10: Loads write the memory word they read to register ir[11:9].
- R11: After reset, busy, done, mem_req, rf_we and cc_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the instruction on ir when idle |
| ir | input | 16 | Instruction word |
| pc | input | 16 | Program counter of the instruction |
| rf_base_sel | output | 3 | Register-file read select for the base register (ir[8:6]) |
| rf_data_sel | output | 3 | Register-file read select for the store data register (ir[11:9]) |
| rf_base_val | input | 16 | Value of the base register |
| rf_data_val | input | 16 | Value of the store data register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory finishes the request this cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write select |
| rf_wdata | output | 16 | Register write data |
| cc_we | output | 1 | Condition code update enable |
| cc_nzp | output | 3 | New condition codes {N,Z,P} |
| done | output | 1 | Instruction complete (one cycle) |
| busy | output | 1 | An instruction is in progress |

## Verification
All results appear on the single `S_DONE` cycle: the register write, the condition codes and `done` itself. The bench predicts that cycle from the wait count it programs into its memory model: 1 cycle after start for address computation, L+2 cycles for one access, and 2L+3 cycles for two. It samples one time unit after each falling edge. It compares the measured count against that prediction, and reads the write port and stored memory only then. While a request waits, it compares `mem_addr` on consecutive samples. For an ignored start, it watches several cycles for any request or `done`.

// File: rtl/pgls_pkg.sv
package pgls_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PTR,
        S_ACC,
        S_DONE
    } pgls_state_e;

    typedef enum logic [2:0] {
        K_LD,
        K_LDR,
        K_LDI,
        K_LEA,
        K_ST,
        K_STR,
        K_STI,
        K_BAD
    } pgls_kind_e;

    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_LEA = 4'b1110;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_STR = 4'b0111;
    localparam logic [3:0] OPC_STI = 4'b1011;

endpackage

// File: rtl/pgls_addr_gen.sv
module pgls_addr_gen #(
    parameter int DATA_W   = 16,
    parameter int PG_OFF_W = 9,
    parameter int BOFS_W   = 6
) (
    input  logic [DATA_W-1:0] ir,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] page_addr,
    output logic [DATA_W-1:0] base_addr
);
    localparam int PAGE_W = DATA_W - PG_OFF_W;
    localparam int ZEXT_W = DATA_W - BOFS_W;

    // page number from the program counter, word-in-page from the instruction (R1)
    assign page_addr = {pc[DATA_W-1 -: PAGE_W], ir[PG_OFF_W-1:0]};
    // unsigned offset, zero-extended before the add (R2)
    assign base_addr = base + {{ZEXT_W{1'b0}}, ir[BOFS_W-1:0]};
endmodule

// File: rtl/pgls_cc_gen.sv
module pgls_cc_gen #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    output logic [2:0]        nzp
);
    always_comb begin
        if (value[DATA_W-1])
            nzp = 3'b100;
        else if (value == '0)
            nzp = 3'b010;
        else
            nzp = 3'b001;
    end
endmodule

// File: rtl/pgls_seq.sv
module pgls_seq
    import pgls_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PG_OFF_W = 9,
    parameter int BOFS_W   = 6,
    parameter int REG_AW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] ir,
    input  logic [DATA_W-1:0] pc,
    output logic [REG_AW-1:0] rf_base_sel,
    output logic [REG_AW-1:0] rf_data_sel,
    input  logic [DATA_W-1:0] rf_base_val,
    input  logic [DATA_W-1:0] rf_data_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              cc_we,
    output logic [2:0]        cc_nzp,
    output logic              done,
    output logic              busy
);
    localparam int DR_LSB = PG_OFF_W;
    localparam int BR_LSB = BOFS_W;

    pgls_state_e       state, state_nx;
    pgls_kind_e        kind_in, kind_q;
    logic [REG_AW-1:0] dr_q;
    logic [DATA_W-1:0] addr_q, data_q, result_q;
    logic [DATA_W-1:0] page_addr, base_addr;
    logic              store_q;

    assign rf_base_sel = ir[BR_LSB +: REG_AW];
    assign rf_data_sel = ir[DR_LSB +: REG_AW];

    always_comb begin
        unique case (ir[DATA_W-1 -: 4])
            OPC_LD:  kind_in = K_LD;
            OPC_LDR: kind_in = K_LDR;
            OPC_LDI: kind_in = K_LDI;
            OPC_LEA: kind_in = K_LEA;
            OPC_ST:  kind_in = K_ST;
            OPC_STR: kind_in = K_STR;
            OPC_STI: kind_in = K_STI;
            default: kind_in = K_BAD;
        endcase
    end

    pgls_addr_gen #(
        .DATA_W  (DATA_W),
        .PG_OFF_W(PG_OFF_W),
        .BOFS_W  (BOFS_W)
    ) addr_i (
        .ir       (ir),
        .pc       (pc),
        .base     (rf_base_val),
        .page_addr(page_addr),
        .base_addr(base_addr)
    );

    pgls_cc_gen #(.DATA_W(DATA_W)) cc_i (
        .value(result_q),
        .nzp  (cc_nzp)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    unique case (kind_in)
                        K_LEA:        state_nx = S_DONE;
                        K_LDI, K_STI: state_nx = S_PTR;
                        K_BAD:        state_nx = S_IDLE;
                        default:      state_nx = S_ACC;
                    endcase
                end
            end
            S_PTR:  if (mem_rdy) state_nx = S_ACC;
            S_ACC:  if (mem_rdy) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // operand and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= K_BAD;
            store_q  <= 1'b0;
            dr_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            result_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start && kind_in != K_BAD) begin
                        kind_q   <= kind_in;
                        store_q  <= (kind_in == K_ST) || (kind_in == K_STR) || (kind_in == K_STI);
                        dr_q     <= ir[DR_LSB +: REG_AW];
                        data_q   <= rf_data_val;
                        addr_q   <= (kind_in == K_LDR || kind_in == K_STR) ? base_addr : page_addr;
                        result_q <= page_addr;
                    end
                end
                S_PTR:  if (mem_rdy) addr_q <= mem_rdata;
                S_ACC:  if (mem_rdy && !store_q) result_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = data_q;
        rf_we     = 1'b0;
        rf_waddr  = dr_q;
        rf_wdata  = result_q;
        cc_we     = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_PTR:  mem_req = 1'b1;
            S_ACC: begin
                mem_req = 1'b1;
                mem_we  = store_q;
            end
            S_DONE: begin
                done  = 1'b1;
                rf_we = !store_q;
                cc_we = !store_q;
            end
            default: ;
        endcase
    end

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_lea_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && kind_in == K_LEA) |=> (done && !mem_req));

    a_r8_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && kind_in == K_BAD) |=> !busy);

    a_r5_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> $onehot(cc_nzp));

    a_r6_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q inside {K_ST, K_STR, K_STI}) |-> (!rf_we && !cc_we));
endmodule

// File: tb/pgls_seq_tb.sv
module pgls_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ir = '0, pc = '0;
    logic [2:0]  rf_base_sel, rf_data_sel;
    logic [15:0] rf_base_val, rf_data_val;
    logic        mem_req, mem_we, mem_rdy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        rf_we, cc_we, done, busy;
    logic [2:0]  rf_waddr, cc_nzp;
    logic [15:0] rf_wdata;

    int n_chk = 0, n_bad = 0, lat = 0, wcnt = 0, cycles = 0;
    logic [15:0] mem [0:1023];

    localparam logic [15:0] REGS [8] = '{16'h0000, 16'h0100, 16'h0005, 16'h8000,
                                         16'h0300, 16'h1234, 16'h0000, 16'hFFFF};

    always #4 clk = ~clk;

    assign rf_base_val = REGS[rf_base_sel];
    assign rf_data_val = REGS[rf_data_sel];

    pgls_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ir(ir), .pc(pc),
        .rf_base_sel(rf_base_sel), .rf_data_sel(rf_data_sel),
        .rf_base_val(rf_base_val), .rf_data_val(rf_data_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .cc_we(cc_we), .cc_nzp(cc_nzp), .done(done), .busy(busy)
    );

    // memory responder: answers after lat wait cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] = '0;
            mem[10'h205] = 16'h0042;
            mem[10'h010] = 16'hFFF0;
            mem[10'h13F] = 16'h7000;
            mem[10'h220] = 16'h0150;
            mem[10'h150] = 16'h8001;
            mem[10'h230] = 16'h0160;
            mem_rdy   = 1'b0;
            mem_rdata = '0;
            wcnt      = 0;
        end else if (mem_req) begin
            if (wcnt == lat) begin
                mem_rdy   = 1'b1;
                mem_rdata = mem[mem_addr[9:0]];
                if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                wcnt = 0;
            end else begin
                mem_rdy = 1'b0;
                wcnt++;
            end
        end else begin
            mem_rdy = 1'b0;
            wcnt    = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // issue one instruction and collect the completion cycle
    task automatic run_op(input logic [15:0] i_ir, input logic [15:0] i_pc, input int i_lat,
                          output int cyc, output logic o_we, output logic o_ccwe,
                          output logic [2:0] o_wa, output logic [15:0] o_wd,
                          output logic [2:0] o_nzp, output int glitch);
        logic        p_req, p_rdy;
        logic [15:0] p_addr;
        lat = i_lat; ir = i_ir; pc = i_pc; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0; cyc = 1; glitch = 0; p_req = 1'b0; p_rdy = 1'b0; p_addr = '0;
        while (!done && cyc < 200) begin
            if (mem_req && p_req && !p_rdy && mem_addr != p_addr) glitch++;
            p_req = mem_req; p_rdy = mem_rdy; p_addr = mem_addr;
            @(negedge clk); #1;
            cyc++;
        end
        o_we = rf_we; o_ccwe = cc_we; o_wa = rf_waddr; o_wd = rf_wdata; o_nzp = cc_nzp;
    endtask

    typedef struct packed {
        logic [15:0] ir;
        logic [15:0] pc;
        logic [3:0]  lat;
        logic        we;
        logic [15:0] wd;
        logic [2:0]  nzp;
        logic [4:0]  cyc;
        logic [15:0] caddr;
        logic [15:0] cval;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{16'h2405, 16'h0200, 4'd0, 1'b1, 16'h0042, 3'b001, 5'd2, 16'h0, 16'h0},    // R1 R10 direct load
        '{16'h2C10, 16'h0000, 4'd2, 1'b1, 16'hFFF0, 3'b100, 5'd4, 16'h0, 16'h0},    // R1 R7 negative
        '{16'h607F, 16'h0200, 4'd1, 1'b1, 16'h7000, 3'b001, 5'd3, 16'h0, 16'h0},    // R2 zero-ext offset
        '{16'hAA20, 16'h0200, 4'd1, 1'b1, 16'h8001, 3'b100, 5'd5, 16'h0, 16'h0},    // R3 indirect load
        '{16'hEFFF, 16'h0200, 4'd0, 1'b1, 16'h03FF, 3'b001, 5'd1, 16'h0, 16'h0},    // R4 addr compute
        '{16'hE600, 16'h0000, 4'd0, 1'b1, 16'h0000, 3'b010, 5'd1, 16'h0, 16'h0},    // R4 R5 zero
        '{16'h2800, 16'h01FF, 4'd0, 1'b1, 16'h0000, 3'b010, 5'd2, 16'h0, 16'h0},    // R1 page edge
        '{16'h3A40, 16'h0200, 4'd1, 1'b0, 16'h0000, 3'b000, 5'd3, 16'h0240, 16'h1234}, // R6 direct store
        '{16'h7F02, 16'h0200, 4'd0, 1'b0, 16'h0000, 3'b000, 5'd2, 16'h0302, 16'hFFFF}, // R2 R6 based store
        '{16'hB430, 16'h0200, 4'd0, 1'b0, 16'h0000, 3'b000, 5'd3, 16'h0160, 16'h0005}  // R3 indirect store
    };

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        chk(1'b0, "watchdog", 32'(cycles), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int          cyc, gl;
        logic        we, ccwe;
        logic [2:0]  wa, nzp;
        logic [15:0] wd;

        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(!busy && !done && !mem_req && !rf_we && !cc_we, "R11 reset outputs",
            {27'd0, busy, done, mem_req, rf_we, cc_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        foreach (TBL[k]) begin
            run_op(TBL[k].ir, TBL[k].pc, int'(TBL[k].lat), cyc, we, ccwe, wa, wd, nzp, gl);
            chk(cyc == int'(TBL[k].cyc), $sformatf("R9 latency vec%0d", k), 32'(cyc), 32'(TBL[k].cyc));
            chk(gl == 0, $sformatf("R7 address held vec%0d", k), 32'(gl), 32'd0);
            chk(we == TBL[k].we, $sformatf("R6 rf_we vec%0d", k), 32'(we), 32'(TBL[k].we));
            chk(ccwe == TBL[k].we, $sformatf("R5 cc_we vec%0d", k), 32'(ccwe), 32'(TBL[k].we));
            if (TBL[k].we) begin
                chk(wd == TBL[k].wd, $sformatf("R10 write data vec%0d", k), 32'(wd), 32'(TBL[k].wd));
                chk(wa == TBL[k].ir[11:9], $sformatf("R10 write reg vec%0d", k), 32'(wa), 32'(TBL[k].ir[11:9]));
                chk(nzp == TBL[k].nzp, $sformatf("R5 nzp vec%0d", k), 32'(nzp), 32'(TBL[k].nzp));
            end else begin
                chk(mem[TBL[k].caddr[9:0]] == TBL[k].cval, $sformatf("R6 stored word vec%0d", k),
                    32'(mem[TBL[k].caddr[9:0]]), 32'(TBL[k].cval));
            end
            @(negedge clk); #1;
            chk(!done, $sformatf("R9 done single vec%0d", k), 32'(done), 32'd0);
        end

        // R3 pointer word untouched by the indirect store
        chk(mem[10'h230] == 16'h0160, "R3 pointer not written", 32'(mem[10'h230]), 32'h0160);

        // R8 unknown opcode is ignored
        ir = 16'h0123; pc = 16'h0200; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        begin
            int seen = 0;
            for (int t = 0; t < 6; t++) begin
                if (busy || mem_req || done) seen++;
                @(negedge clk); #1;
            end
            chk(seen == 0, "R8 bad opcode ignored", 32'(seen), 32'd0);
        end

        // R9 start while busy is ignored: indirect load with 3 wait cycles
        begin
            int c = 1, dn = 0;
            lat = 3; ir = 16'hAA20; pc = 16'h0200; start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
            @(negedge clk); #1; c++;
            ir = 16'hEFFF; start = 1'b1;
            @(negedge clk); #1; c++;
            start = 1'b0;
            while (!done && c < 200) begin
                @(negedge clk); #1; c++;
            end
            chk(c == 9, "R9 busy latency", 32'(c), 32'd9);
            chk(rf_wdata == 16'h8001 && rf_waddr == 3'd5, "R9 busy result kept",
                32'(rf_wdata), 32'h8001);
            for (int t = 0; t < 5; t++) begin
                @(negedge clk); #1;
                if (done || busy) dn++;
            end
            chk(dn == 0, "R9 second start dropped", 32'(dn), 32'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule